// File: doc/BRIEF.md
# Predicate Flag Register Unit

This block keeps the four condition flags of a programmable port controller and answers 2-bit predicate queries against them. Two flags, A and B, are general purpose and change only through a flags instruction. The sign flag S copies the top bit of the data word each time that bit is loaded. The zero flag Z follows the loop counter's zero indication with no delay.

A flags instruction carries its own predicate and two 8-bit term masks, one for A and one for B. When the predicate holds, each flag takes the OR of the flag terms its mask selects. A mask can select any flag or its complement. An empty mask therefore gives 0, and selecting a flag together with its complement gives 1. Both new values come from the flag state before the clock edge, so A and B can be swapped or cross-coupled in a single instruction.

A separate query port evaluates any predicate code against the live flags. The pump control uses it to decide whether an instruction fires. All pins are plain control signals. Nothing in the block waits on a handshake, and every input is sampled on each clock edge.

Top module: `pfr_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears A, B and S on the clock edge where `rst` is high.
- R2: `pred_true` depends combinationally on `pred_code`. Code 2'b00 gives A, 2'b10 gives B, 2'b01 gives Z and 2'b11 gives 1.
- R3: `flag_z` equals `lc_zero` in the same cycle, and the predicate query follows it in the same cycle.
- R4: On an edge where `dload` is high, S takes the value of `dtop`. When `dload` is low, S keeps its value whatever `dtop` does.
- R5: On an edge where `flg_we` is high and `flg_pred` holds, A takes the OR of the terms that `mask_a` selects, and B does the same with `mask_b`. The mask bits are: bit 7 = A, bit 6 = not A, bit 5 = B, bit 4 = not B, bit 3 = S, bit 2 = not S, bit 1 = Z, bit 0 = not Z.
- R6: An all-zero mask writes 0. A mask that selects a flag together with its complement writes 1.
- R7: When `flg_pred` does not hold, or `flg_we` is low, A and B keep their values. `flg_pred` uses the same code meanings as R2.
- R8: Both updated values are computed from the flags as they stood before the edge, including an S that is reloaded on that same edge.
- R9: A flags instruction never changes S or Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flg_we | input | 1 | Flags instruction strobe |
| flg_pred | input | 2 | Predicate of the flags instruction |
| mask_a | input | 8 | Term mask for the new A |
| mask_b | input | 8 | Term mask for the new B |
| dload | input | 1 | Data word top-bit load strobe |
| dtop | input | 1 | Top bit of the data word being loaded |
| lc_zero | input | 1 | Loop counter equals zero |
| pred_code | input | 2 | Predicate to evaluate |
| flag_a | output | 1 | Flag A |
| flag_b | output | 1 | Flag B |
| flag_s | output | 1 | Flag S |
| flag_z | output | 1 | Flag Z |
| pred_true | output | 1 | Result of evaluating `pred_code` |

## Verification
The assertions assume that every input is a known 0 or 1 at each sampled edge and that `rst` is held for at least one edge before checking begins. The properties on held values also assume that only the named strobes alter the registers. The bench meets these conditions by driving every input to a defined level before the reset edge and by changing inputs only on the falling clock edge. It also returns the strobes to 0 after each single-cycle operation, so that hold behaviour is observed between operations. The cross-coupled and same-edge cases are driven on purpose so that they arise only as intended.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int NUM_TERMS = 2 * NUM_FLAGS;
  localparam int NUM_WFLAGS = 2;

  typedef enum logic [1:0] {
    PRED_A   = 2'b00,
    PRED_Z   = 2'b01,
    PRED_B   = 2'b10,
    PRED_ALL = 2'b11
  } pred_e;

  typedef struct packed {
    logic a;
    logic b;
    logic s;
    logic z;
  } flags_t;
endpackage

// File: rtl/pfr_pred_eval.sv
module pfr_pred_eval
  import pfr_pkg::*;
(
  input  flags_t     flags,
  input  logic [1:0] code,
  output logic       hit
);
  always_comb begin
    unique case (pred_e'(code))
      PRED_A:   hit = flags.a;
      PRED_B:   hit = flags.b;
      PRED_Z:   hit = flags.z;
      default:  hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/pfr_term_or.sv
module pfr_term_or
  import pfr_pkg::*;
#(
  parameter int TERMS = NUM_TERMS
) (
  input  flags_t             flags,
  input  logic [TERMS-1:0]   mask,
  output logic               value
);
  localparam int PAIRS = TERMS / 2;
  logic [PAIRS-1:0] src;
  logic [TERMS-1:0] term;

  // source order from most to least significant pair: A, B, S, Z
  assign src = flags;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign term[2*p+1] = src[p];
    assign term[2*p]   = ~src[p];
  end

  assign value = |(mask & term);
endmodule

// File: rtl/pfr_flag_reg.sv
module pfr_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic next_a,
  input  logic next_b,
  input  logic dload,
  input  logic dtop,
  output logic a_q,
  output logic b_q,
  output logic s_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else if (wr_en) begin
      a_q <= next_a;
      b_q <= next_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        s_q <= 1'b0;
    else if (dload) s_q <= dtop;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!a_q && !b_q && !s_q)); // R1
  AST_S_LOADS: assert property (@(posedge clk) disable iff (rst)
    dload |=> (s_q == $past(dtop))); // R4
  AST_S_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !dload |=> $stable(s_q)); // R4
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(a_q) && $stable(b_q))); // R7
endmodule

// File: rtl/pfr_flag_unit.sv
module pfr_flag_unit
  import pfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       flg_we,
  input  logic [1:0] flg_pred,
  input  logic [7:0] mask_a,
  input  logic [7:0] mask_b,
  input  logic       dload,
  input  logic       dtop,
  input  logic       lc_zero,
  input  logic [1:0] pred_code,
  output logic       flag_a,
  output logic       flag_b,
  output logic       flag_s,
  output logic       flag_z,
  output logic       pred_true
);
  flags_t cur;
  logic   a_q, b_q, s_q;
  logic [1:0] codes [2];
  logic [1:0] hits;
  logic [NUM_TERMS-1:0] masks [NUM_WFLAGS];
  logic [NUM_WFLAGS-1:0] nxt;
  logic   ins_fire;

  assign cur = '{a: a_q, b: b_q, s: s_q, z: lc_zero};

  // slot 0 judges the flags instruction, slot 1 answers the query port
  assign codes[0] = flg_pred;
  assign codes[1] = pred_code;
  for (genvar i = 0; i < 2; i++) begin : g_eval
    pfr_pred_eval u_eval (.flags(cur), .code(codes[i]), .hit(hits[i]));
  end

  assign masks[0] = mask_a;
  assign masks[1] = mask_b;
  for (genvar w = 0; w < NUM_WFLAGS; w++) begin : g_next
    pfr_term_or #(.TERMS(NUM_TERMS)) u_or (
      .flags(cur), .mask(masks[w]), .value(nxt[w]));
  end

  assign ins_fire = flg_we & hits[0];

  pfr_flag_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(ins_fire),
    .next_a(nxt[0]), .next_b(nxt[1]),
    .dload(dload), .dtop(dtop),
    .a_q(a_q), .b_q(b_q), .s_q(s_q));

  assign flag_a    = a_q;
  assign flag_b    = b_q;
  assign flag_s    = s_q;
  assign flag_z    = lc_zero;
  assign pred_true = hits[1];

  AST_PRED_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (pred_code == 2'b11) |-> pred_true); // R2
  AST_PRED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pred_code == 2'b01) |-> (pred_true == lc_zero)); // R3
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
    (ins_fire && mask_a == 8'h00) |=> !flag_a); // R6
  AST_SNAPSHOT_SWAP: assert property (@(posedge clk) disable iff (rst)
    (ins_fire && mask_a == 8'h20 && mask_b == 8'h80)
      |=> (flag_a == $past(flag_b) && flag_b == $past(flag_a))); // R8
  AST_NO_S_WRITE: assert property (@(posedge clk) disable iff (rst)
    (flg_we && !dload) |=> $stable(flag_s)); // R9
endmodule

// File: tb/test_pfr_flag_unit.sv
module test_pfr_flag_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flg_we = 1'b0;
  logic [1:0] flg_pred = 2'b11;
  logic [7:0] mask_a = 8'h00;
  logic [7:0] mask_b = 8'h00;
  logic       dload = 1'b0;
  logic       dtop = 1'b0;
  logic       lc_zero = 1'b0;
  logic [1:0] pred_code = 2'b11;
  logic       flag_a, flag_b, flag_s, flag_z, pred_true;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  pfr_flag_unit i_pfr_flag_unit (
    .clk(clk), .rst(rst), .flg_we(flg_we), .flg_pred(flg_pred),
    .mask_a(mask_a), .mask_b(mask_b), .dload(dload), .dtop(dtop),
    .lc_zero(lc_zero), .pred_code(pred_code),
    .flag_a(flag_a), .flag_b(flag_b), .flag_s(flag_s),
    .flag_z(flag_z), .pred_true(pred_true));

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  // one flags instruction; results visible on return
  task automatic flags_op(input logic [1:0] p, input logic [7:0] ma, input logic [7:0] mb);
    @(negedge clk);
    flg_we = 1'b1; flg_pred = p; mask_a = ma; mask_b = mb;
    @(negedge clk);
    flg_we = 1'b0;
  endtask

  task automatic set_ab(input logic a, input logic b);
    flags_op(2'b11, a ? 8'hC0 : 8'h00, b ? 8'h30 : 8'h00);
  endtask

  task automatic t_reset();
    set_ab(1'b1, 1'b1);
    @(negedge clk); dload = 1'b1; dtop = 1'b1;
    @(negedge clk); dload = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1", "A after reset", flag_a, 1'b0);
    chk("R1", "B after reset", flag_b, 1'b0);
    chk("R1", "S after reset", flag_s, 1'b0);
  endtask

  task automatic t_pred();
    set_ab(1'b1, 1'b0);
    lc_zero = 1'b0;
    pred_code = 2'b00; #1 chk("R2", "code00 A=1", pred_true, 1'b1);
    pred_code = 2'b10; #1 chk("R2", "code10 B=0", pred_true, 1'b0);
    pred_code = 2'b01; #1 chk("R2", "code01 Z=0", pred_true, 1'b0);
    pred_code = 2'b11; #1 chk("R2", "code11", pred_true, 1'b1);
    set_ab(1'b0, 1'b1);
    pred_code = 2'b00; #1 chk("R2", "code00 A=0", pred_true, 1'b0);
    pred_code = 2'b10; #1 chk("R2", "code10 B=1", pred_true, 1'b1);
  endtask

  task automatic t_zflag();
    @(negedge clk);
    lc_zero = 1'b1; pred_code = 2'b01;
    #1 chk("R3", "Z follows 1", flag_z, 1'b1);
    chk("R3", "pred Z=1", pred_true, 1'b1);
    lc_zero = 1'b0;
    #1 chk("R3", "Z follows 0", flag_z, 1'b0);
    chk("R3", "pred Z=0", pred_true, 1'b0);
  endtask

  task automatic t_sload();
    @(negedge clk); dload = 1'b1; dtop = 1'b1;
    @(negedge clk); dload = 1'b0; dtop = 1'b0;
    chk("R4", "S loaded 1", flag_s, 1'b1);
    @(negedge clk);
    chk("R4", "S held without strobe", flag_s, 1'b1);
    dload = 1'b1; dtop = 1'b0;
    @(negedge clk); dload = 1'b0; dtop = 1'b1;
    @(negedge clk);
    chk("R4", "S loaded 0 and held", flag_s, 1'b0);
  endtask

  task automatic t_masks();
    // A=1, B=0, S=0, Z=1
    set_ab(1'b1, 1'b0);
    lc_zero = 1'b1;
    flags_op(2'b11, 8'h10, 8'h02); // A<=~B=1, B<=Z=1
    chk("R5", "A<=notB", flag_a, 1'b1);
    chk("R5", "B<=Z", flag_b, 1'b1);
    flags_op(2'b11, 8'h09, 8'h44); // A<=S|~Z=0, B<=~A|~S=0|1=1
    chk("R5", "A<=S|notZ", flag_a, 1'b0);
    chk("R5", "B<=notA|notS", flag_b, 1'b1);
    lc_zero = 1'b0;
  endtask

  task automatic t_const();
    set_ab(1'b1, 1'b1);
    flags_op(2'b11, 8'h00, 8'h00);
    chk("R6", "empty mask A", flag_a, 1'b0);
    chk("R6", "empty mask B", flag_b, 1'b0);
    flags_op(2'b11, 8'h0C, 8'h03);
    chk("R6", "S|notS A", flag_a, 1'b1);
    chk("R6", "Z|notZ B", flag_b, 1'b1);
  endtask

  task automatic t_pred_false();
    set_ab(1'b0, 1'b1);
    flags_op(2'b00, 8'hC0, 8'h00); // A=0: no effect
    chk("R7", "pred A false keeps A", flag_a, 1'b0);
    chk("R7", "pred A false keeps B", flag_b, 1'b1);
    lc_zero = 1'b0;
    flags_op(2'b01, 8'hC0, 8'h00); // Z=0: no effect
    chk("R7", "pred Z false keeps A", flag_a, 1'b0);
    chk("R7", "pred Z false keeps B", flag_b, 1'b1);
    flags_op(2'b10, 8'hC0, 8'h00); // B=1: applies
    chk("R7", "pred B true writes A", flag_a, 1'b1);
    chk("R7", "pred B true writes B", flag_b, 1'b0);
  endtask

  task automatic t_snapshot();
    set_ab(1'b1, 1'b0);
    flags_op(2'b11, 8'h20, 8'h80); // swap
    chk("R8", "swap A", flag_a, 1'b0);
    chk("R8", "swap B", flag_b, 1'b1);
    // S=0 now reloaded to 1 on same edge; A reads old S
    @(negedge clk);
    flg_we = 1'b1; flg_pred = 2'b11; mask_a = 8'h08; mask_b = 8'h04;
    dload = 1'b1; dtop = 1'b1;
    @(negedge clk);
    flg_we = 1'b0; dload = 1'b0; dtop = 1'b0;
    chk("R8", "A from old S", flag_a, 1'b0);
    chk("R8", "B from old notS", flag_b, 1'b1);
    chk("R8", "S reloaded", flag_s, 1'b1);
  endtask

  task automatic t_sz_untouched();
    lc_zero = 1'b1;
    flags_op(2'b11, 8'hFF, 8'h00);
    chk("R9", "S unchanged by flags op", flag_s, 1'b1);
    chk("R9", "Z unchanged by flags op", flag_z, 1'b1);
    lc_zero = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pred();
    t_zflag();
    t_sload();
    t_masks();
    t_const();
    t_pred_false();
    t_snapshot();
    t_sz_untouched();
    finish_run();
  end

  initial begin
    #(8 * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule